// File: doc/BRIEF.md
# Supervisor Interrupt Selector with Compare Timer

This block decides, on each cycle where it is asked to evaluate, whether a supervisor-level interrupt should be taken and which one. Three pending sources feed it: a software request, an external request line coming from the interrupt controller, and a timer bit that the block derives itself by comparing a free-running microsecond time value against a 64-bit compare register.

The pending vector is masked by the interrupt-enable vector. The result is gated either by the global supervisor-interrupt-enable bit or by the hart running in the lowest privilege mode. When an interrupt is taken, the block raises a one-cycle trap request together with a 32-bit cause code naming the winning source. Software programs the compare register as two 32-bit halves through a small write port. Trap vectoring and status-register updates stay with the surrounding core.

Top module: `sup_irq_select`

## Requirements
- R1: `timer_pend` (pending bit 5) is 1 exactly when `time_now` is strictly greater than the compare value, and it follows `time_now` in the same cycle; equality gives 0.
- R2: After reset the compare value is 0x0FFF_FFFF_FFFF_FFFF, so `time_now` equal to that value gives `timer_pend`=0 and `time_now`=0x1000_0000_0000_0000 gives 1.
- R3: A clock edge with `cmp_we`=1 writes `cmp_wdata` into the low half of the compare value when `cmp_hi`=0, or into the high half when `cmp_hi`=1. The other half is left unchanged, and the new value applies from the following cycle.
- R4: An interrupt is taken only when (pending AND `irq_en`) is non-zero and either `sie` is 1 or `priv` equals 0. With `sie`=0 and `priv` non-zero, nothing is taken.
- R5: When several enabled sources are pending, the highest bit index wins: external (bit 9) over timer (bit 5) over software (bit 1).
- R6: The cause code is 0x80000001 for software, 0x80000005 for timer and 0x80000009 for external.
- R7: `trap_req` is high for exactly the one cycle after an edge where `eval`=1 and an interrupt is taken. An edge with `eval`=0 leaves `trap_req` low in the next cycle. `trap_cause` is 0 whenever `trap_req` is 0.
- R8: Bits of `irq_en` other than 1, 5 and 9 have no effect on whether a trap is taken.
- R9: During and right after reset, `trap_req` is 0 and `trap_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running microsecond time |
| cmp_we | input | 1 | Compare-register write strobe |
| cmp_hi | input | 1 | Selects the high half (1) or the low half (0) |
| cmp_wdata | input | 32 | Data for the selected half |
| sw_pend | input | 1 | Software interrupt pending (bit 1) |
| ext_line | input | 1 | External interrupt line from the controller (bit 9) |
| irq_en | input | 32 | Interrupt-enable vector |
| sie | input | 1 | Global supervisor interrupt enable |
| priv | input | 2 | Current privilege level, 0 = lowest |
| eval | input | 1 | Evaluate strobe |
| timer_pend | output | 1 | Timer pending bit (combinational) |
| trap_req | output | 1 | Trap request pulse |
| trap_cause | output | 32 | Cause code, valid with `trap_req` |

## Verification
The assertions assume that `priv`, `sie`, `irq_en` and the pending inputs are stable around the evaluating edge. They also assume the enable vector may carry arbitrary bits outside positions 1, 5 and 9. The bench drives every input on the falling edge only, so each evaluation sees one settled input set. It samples `trap_req` and `trap_cause` between edges in the cycle after the evaluating edge. Timer cases place `time_now` just above, at, and below the compare value, so the strict comparison is exercised at its boundary.

// File: rtl/sup_irq_select.sv
module sup_irq_select #(
  parameter int          TW       = 64,
  parameter int          CW       = 32,
  parameter logic [63:0] CMP_INIT = 64'h0FFF_FFFF_FFFF_FFFF,
  parameter int          SW_BIT   = 1,
  parameter int          TM_BIT   = 5,
  parameter int          EX_BIT   = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   time_now,
  input  logic          cmp_we,
  input  logic          cmp_hi,
  input  logic [31:0]   cmp_wdata,
  input  logic          sw_pend,
  input  logic          ext_line,
  input  logic [31:0]   irq_en,
  input  logic          sie,
  input  logic [1:0]    priv,
  input  logic          eval,
  output logic          timer_pend,
  output logic          trap_req,
  output logic [31:0]   trap_cause
);
  localparam int HALF = TW / 2;
  localparam int IW   = $clog2(CW);

  logic [TW-1:0] cmp_q;
  logic [CW-1:0] pend, hit;
  logic [IW-1:0] win;
  logic          known, take;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cmp_q <= CMP_INIT[TW-1:0];
    else if (cmp_we) begin
      if (cmp_hi) cmp_q[TW-1:HALF] <= cmp_wdata[HALF-1:0];
      else        cmp_q[HALF-1:0]  <= cmp_wdata[HALF-1:0];
    end
  end

  assign timer_pend = time_now[TW-1:0] > cmp_q;

  always_comb begin
    pend         = '0;
    pend[SW_BIT] = sw_pend;
    pend[TM_BIT] = timer_pend;
    pend[EX_BIT] = ext_line;
  end

  assign hit = pend & irq_en[CW-1:0];

  always_comb begin
    win = '0;
    for (int i = 0; i < CW; i++)
      if (hit[i]) win = IW'(i);
  end

  assign known = (win == IW'(SW_BIT)) || (win == IW'(TM_BIT)) || (win == IW'(EX_BIT));
  assign take  = eval && (|hit) && (sie || priv == 2'd0) && known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= take;
      trap_cause <= take ? ({1'b1, {(CW-1){1'b0}}} | CW'(win)) : '0;
    end
  end
endmodule

// File: rtl/sup_irq_select_chk.sv
module sup_irq_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        eval,
  input logic        sie,
  input logic [1:0]  priv,
  input logic        sw_pend,
  input logic        ext_line,
  input logic [31:0] irq_en,
  input logic        timer_pend,
  input logic        trap_req,
  input logic [31:0] trap_cause
);
  p_eval_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(eval));

  p_cause_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> trap_cause == 32'h0);

  p_cause_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_cause == 32'h8000_0001 || trap_cause == 32'h8000_0005 ||
                  trap_cause == 32'h8000_0009));

  p_take_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(sie || priv == 2'd0));

  p_ext_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause == 32'h8000_0009) |-> $past(ext_line && irq_en[9]));

  p_tmr_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause == 32'h8000_0005) |->
      $past(timer_pend && irq_en[5] && !(ext_line && irq_en[9])));

  p_sw_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause == 32'h8000_0001) |->
      $past(sw_pend && irq_en[1] && !(ext_line && irq_en[9]) && !(timer_pend && irq_en[5])));
endmodule

bind sup_irq_select sup_irq_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eval(eval), .sie(sie), .priv(priv),
  .sw_pend(sw_pend), .ext_line(ext_line), .irq_en(irq_en),
  .timer_pend(timer_pend), .trap_req(trap_req), .trap_cause(trap_cause)
);

// File: tb/sup_irq_select_tb.sv
module sup_irq_select_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] time_now = 0;
  logic        cmp_we = 0, cmp_hi = 0;
  logic [31:0] cmp_wdata = 0;
  logic        sw_pend = 0, ext_line = 0, sie = 0, eval = 0;
  logic [31:0] irq_en = 0;
  logic [1:0]  priv = 0;
  logic        timer_pend, trap_req;
  logic [31:0] trap_cause;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sup_irq_select u_dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .cmp_we(cmp_we), .cmp_hi(cmp_hi),
    .cmp_wdata(cmp_wdata), .sw_pend(sw_pend), .ext_line(ext_line), .irq_en(irq_en),
    .sie(sie), .priv(priv), .eval(eval), .timer_pend(timer_pend),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  // {sw, ext, tbig, sie, priv[1:0], en[11:0], req, idx[3:0]}
  localparam int NV = 11;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,2'd1,12'h222,1'b1,4'd1},
    {1'b1,1'b1,1'b1,1'b1,2'd1,12'h222,1'b1,4'd9},
    {1'b1,1'b0,1'b1,1'b1,2'd1,12'h222,1'b1,4'd5},
    {1'b1,1'b1,1'b1,1'b1,2'd1,12'h022,1'b1,4'd5},
    {1'b1,1'b1,1'b1,1'b0,2'd1,12'h222,1'b0,4'd0},
    {1'b1,1'b1,1'b1,1'b0,2'd0,12'h222,1'b1,4'd9},
    {1'b0,1'b0,1'b0,1'b1,2'd1,12'h222,1'b0,4'd0},
    {1'b1,1'b1,1'b1,1'b1,2'd1,12'hDDD,1'b0,4'd0},
    {1'b1,1'b0,1'b0,1'b0,2'd3,12'h222,1'b0,4'd0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,12'h002,1'b1,4'd1},
    {1'b0,1'b1,1'b0,1'b1,2'd2,12'h200,1'b1,4'd9}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_cmp(input logic hi, input logic [31:0] d);
    @(negedge clk);
    cmp_we = 1; cmp_hi = hi; cmp_wdata = d;
    @(negedge clk);
    cmp_we = 0;
  endtask

  task automatic fire_and_check(input string req, input logic exp_req, input logic [31:0] exp_cause);
    @(negedge clk); eval = 1;
    @(posedge clk); #2;
    check(req, {63'd0, trap_req}, {63'd0, exp_req});
    check(req, {32'd0, trap_cause}, {32'd0, exp_cause});
    @(negedge clk); eval = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 req", {63'd0, trap_req}, 64'd0);
    check("R9 cause", {32'd0, trap_cause}, 64'd0);
    @(negedge clk); rst_n = 1;
    time_now = 64'h0FFF_FFFF_FFFF_FFFF; #1;
    check("R2 at reset cmp", {63'd0, timer_pend}, 64'd0);
    time_now = 64'h1000_0000_0000_0000; #1;
    check("R2 above reset cmp", {63'd0, timer_pend}, 64'd1);

    wr_cmp(1'b0, 32'd1000);
    time_now = 64'h0FFF_FFFF_0000_03E9; #1;
    check("R3 low half only", {63'd0, timer_pend}, 64'd1);
    time_now = 64'h0FFF_FFFF_0000_03E8; #1;
    check("R3 low half equal", {63'd0, timer_pend}, 64'd0);
    wr_cmp(1'b1, 32'd0);
    time_now = 64'd1000; #1;
    check("R1 equality", {63'd0, timer_pend}, 64'd0);
    time_now = 64'd1001; #1;
    check("R1 above", {63'd0, timer_pend}, 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      sw_pend = v[22]; ext_line = v[21];
      time_now = v[20] ? 64'd2000 : 64'd500;
      sie = v[19]; priv = v[18:17]; irq_en = {20'd0, v[16:5]};
      #1;
      check("R1 vec timer", {63'd0, timer_pend}, {63'd0, v[20]});
      fire_and_check("R4 R5 R6 R8 vec", v[4],
                     v[4] ? (32'h8000_0000 | {28'd0, v[3:0]}) : 32'd0);
    end

    // R7: no evaluate strobe, no trap; one pulse per strobe
    @(negedge clk);
    sw_pend = 1; ext_line = 0; time_now = 64'd0; sie = 1; priv = 2'd1; irq_en = 32'h2; eval = 0;
    @(posedge clk); #2;
    check("R7 no eval", {63'd0, trap_req}, 64'd0);
    fire_and_check("R7 pulse", 1'b1, 32'h8000_0001);
    @(posedge clk); #2;
    check("R7 pulse ends", {63'd0, trap_req}, 64'd0);
    check("R7 cause cleared", {32'd0, trap_cause}, 64'd0);

    // R8: enable bits outside 1/5/9 with all sources pending
    @(negedge clk);
    sw_pend = 1; ext_line = 1; time_now = 64'd5000; irq_en = 32'hFFFF_FDDD;
    fire_and_check("R8 stray enables", 1'b0, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule